// File: doc/BRIEF.md
# Privileged Register Access-Check Unit

This block holds one 64-bit privileged control register that describes the start of a memory region: a valid flag in bit 0 and a start-address field whose lowest sixteen address bits are implied zero. Every read or write request that carries the register's five-field encoding is judged against the current privilege level and a set of control bits. The request either completes, is reported as an undefined instruction, or traps to the hypervisor level (2) or the monitor level (3).

The judgement is a fixed priority ladder that differs by privilege level. Level 0 is always refused. Level 1 is checked against monitor-level secure state and undefined-priority options, then the hypervisor coarse and fine-grained traps, then the monitor trap. Level 2 sees only the monitor-level conditions. Level 3 needs only the non-secure state. Each outcome is reported one cycle after the request. A refused write leaves the register untouched, and a refused read returns zero.

The physical address width is a parameter of 48, 52 or 56. Bits outside the implemented field read as zero, and writes to them are dropped.

Top module: `priv_reg_gate`

## Requirements
- R1: Only the encoding op0=3, op1=0, crn=10, crm=4, op2=0 selects the register. A request with any other encoding raises no pulse, returns zero read data and does not change the register.
- R2: Any selected access with cur_el=0 raises undef_pulse.
- R3: At cur_el=1 the first matching rule wins, in this order:
  - monitor present, undefined-priority set and monitor trap set: undefined;
  - monitor present and ns_state=0: undefined;
  - hypervisor enabled and hypervisor trap set: trap to level 2;
  - fine-grained trap (see R4): trap to level 2;
  - monitor present and monitor trap set: undefined if the undefined option is set, otherwise trap to level 3;
  - otherwise the access completes.
- R4: The fine-grained trap at level 1 applies only under all of these conditions:
  - the hypervisor is enabled;
  - fine-grained traps are implemented;
  - either no monitor is present or the monitor fine-grained enable is 1;
  - the bit for the access direction is set (fgt_rd_trap for reads, fgt_wr_trap for writes).
- R5: At cur_el=2, with a monitor present, the first matching rule wins:
  - ns_state=0: undefined;
  - undefined-priority and monitor trap both set: undefined;
  - monitor trap set: undefined or trap to level 3, following the undefined option;
  - otherwise the access completes.
  Without a monitor, the access completes.
- R6: At cur_el=3 a selected access is undefined when ns_state=0 and completes otherwise.
- R7: Every trap reports trap_class=0x18 and trap_level=2 or 3 (the target level in binary). When trap_pulse is 0, both fields are zero.
- R8: Bit 0 of the register is the valid flag (1 = region enabled). It is written and read back as is.
- R9: Bits [PA-1:16] hold start-address bits [PA-1:16]. All other bits (bits [15:1] and bits PA and above) read as zero, and writes to them are ignored.
- R10: After reset the register is all zero, and rd_data, undef_pulse and trap_pulse are 0.
- R11: undef_pulse and trap_pulse are single-cycle pulses in the cycle after the request, and never both high. A refused write leaves the register unchanged, and a refused read returns zero.
- R12: A completed read presents the register value on rd_data in the cycle after the request. rd_data is zero in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_op0 | input | 2 | Encoding field op0 |
| req_op1 | input | 3 | Encoding field op1 |
| req_crn | input | 4 | Encoding field crn |
| req_crm | input | 4 | Encoding field crm |
| req_op2 | input | 3 | Encoding field op2 |
| req_wdata | input | 64 | Write data |
| cur_el | input | 2 | Current privilege level 0..3 |
| ns_state | input | 1 | Non-secure state (0 = secure) |
| hyp_trap | input | 1 | Hypervisor coarse trap enable |
| mon_trap | input | 1 | Monitor trap enable |
| fgt_rd_trap | input | 1 | Fine-grained read trap bit |
| fgt_wr_trap | input | 1 | Fine-grained write trap bit |
| fgt_impl | input | 1 | Fine-grained traps implemented |
| mon_fgt_en | input | 1 | Monitor allows fine-grained traps |
| has_mon | input | 1 | Monitor level present |
| hyp_en | input | 1 | Hypervisor level enabled |
| mon_undef_opt | input | 1 | Monitor trap becomes undefined |
| mon_undef_prio | input | 1 | Undefined takes top priority |
| rd_data | output | 64 | Read data of a completed read, else zero |
| undef_pulse | output | 1 | Undefined-instruction pulse |
| trap_pulse | output | 1 | Trap pulse |
| trap_level | output | 2 | Trap target level |
| trap_class | output | 6 | Exception class of the trap |

## Verification
The bench targets the points where ladder rules overlap:
- Undefined-priority against the hypervisor trap at level 1: a design with the rungs swapped would trap to level 2 instead of reporting undefined.
- A fine-grained bit for the other access direction: a design that takes the wrong bit would trap a read that should complete.
- Monitor fine-grained enable cleared while a monitor is present: a design that ignores the enable would trap.
- Writes of all ones, in order to expose reserved bits that leak through the mask.
- Trapped and mismatched-encoding writes followed by reads: a design that commits them would return the new value.

// File: rtl/priv_gate_pkg.sv
package priv_gate_pkg;

  typedef enum logic [1:0] {
    VERDICT_DONE     = 2'd0,
    VERDICT_UNDEF    = 2'd1,
    VERDICT_TRAP_HYP = 2'd2,
    VERDICT_TRAP_MON = 2'd3
  } verdict_e;

  typedef struct packed {
    logic ns;
    logic hyp_trap;
    logic mon_trap;
    logic fgt_rd;
    logic fgt_wr;
    logic fgt_impl;
    logic mon_fgt_en;
    logic has_mon;
    logic hyp_en;
    logic undef_opt;
    logic undef_prio;
  } gate_ctl_t;

  localparam logic [5:0] TRAP_EC   = 6'h18;
  localparam int         ADDR_LSB  = 16;
  localparam int         FIELD_TOP = 56;

  // Register selector fields
  localparam logic [1:0] SEL_OP0 = 2'd3;
  localparam logic [2:0] SEL_OP1 = 3'd0;
  localparam logic [3:0] SEL_CRN = 4'd10;
  localparam logic [3:0] SEL_CRM = 4'd4;
  localparam logic [2:0] SEL_OP2 = 3'd0;

  // Writable / readable bits of the register for a given address width
  function automatic logic [63:0] keep_mask(input int pa);
    logic [63:0] m;
    for (int i = 0; i < 64; i++) begin
      m[i] = (i == 0) || ((i >= ADDR_LSB) && (i < pa) && (i < FIELD_TOP));
    end
    return m;
  endfunction

  function automatic verdict_e mon_outcome(input logic undef_opt);
    return undef_opt ? VERDICT_UNDEF : VERDICT_TRAP_MON;
  endfunction

  function automatic verdict_e judge(input logic [1:0] el, input logic wr,
                                     input gate_ctl_t c);
    logic fgt_allowed;
    logic fgt_bit;
    fgt_allowed = c.fgt_impl && (!c.has_mon || c.mon_fgt_en);
    fgt_bit     = wr ? c.fgt_wr : c.fgt_rd;
    unique case (el)
      2'd0: return VERDICT_UNDEF;
      2'd1: begin
        if (c.has_mon && c.undef_prio && c.mon_trap) return VERDICT_UNDEF;
        else if (c.has_mon && !c.ns)                 return VERDICT_UNDEF;
        else if (c.hyp_en && c.hyp_trap)             return VERDICT_TRAP_HYP;
        else if (c.hyp_en && fgt_allowed && fgt_bit) return VERDICT_TRAP_HYP;
        else if (c.has_mon && c.mon_trap)            return mon_outcome(c.undef_opt);
        else                                         return VERDICT_DONE;
      end
      2'd2: begin
        if (c.has_mon && !c.ns)                      return VERDICT_UNDEF;
        else if (c.has_mon && c.undef_prio && c.mon_trap) return VERDICT_UNDEF;
        else if (c.has_mon && c.mon_trap)            return mon_outcome(c.undef_opt);
        else                                         return VERDICT_DONE;
      end
      default: return c.ns ? VERDICT_DONE : VERDICT_UNDEF;
    endcase
  endfunction

endpackage

// File: rtl/priv_enc_match.sv
module priv_enc_match
  import priv_gate_pkg::*;
(
  input  logic [1:0] op0,
  input  logic [2:0] op1,
  input  logic [3:0] crn,
  input  logic [3:0] crm,
  input  logic [2:0] op2,
  output logic       hit
);
  assign hit = (op0 == SEL_OP0) && (op1 == SEL_OP1) && (crn == SEL_CRN) &&
               (crm == SEL_CRM) && (op2 == SEL_OP2);
endmodule

// File: rtl/priv_access_ladder.sv
module priv_access_ladder
  import priv_gate_pkg::*;
(
  input  logic [1:0] el,
  input  logic       is_write,
  input  gate_ctl_t  ctl,
  output verdict_e   verdict
);
  always_comb verdict = judge(el, is_write, ctl);
endmodule

// File: rtl/priv_region_store.sv
module priv_region_store
  import priv_gate_pkg::*;
#(
  parameter int PA = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wdata,
  output logic [63:0] value
);
  localparam logic [63:0] MASK = keep_mask(PA);

  logic [63:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= wdata & MASK;
  end

  assign value = q & MASK;
endmodule

// File: rtl/priv_reg_gate.sv
module priv_reg_gate
  import priv_gate_pkg::*;
#(
  parameter int PA = 52
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [1:0]  req_op0,
  input  logic [2:0]  req_op1,
  input  logic [3:0]  req_crn,
  input  logic [3:0]  req_crm,
  input  logic [2:0]  req_op2,
  input  logic [63:0] req_wdata,
  input  logic [1:0]  cur_el,
  input  logic        ns_state,
  input  logic        hyp_trap,
  input  logic        mon_trap,
  input  logic        fgt_rd_trap,
  input  logic        fgt_wr_trap,
  input  logic        fgt_impl,
  input  logic        mon_fgt_en,
  input  logic        has_mon,
  input  logic        hyp_en,
  input  logic        mon_undef_opt,
  input  logic        mon_undef_prio,
  output logic [63:0] rd_data,
  output logic        undef_pulse,
  output logic        trap_pulse,
  output logic [1:0]  trap_level,
  output logic [5:0]  trap_class
);

  initial begin
    if (PA != 48 && PA != 52 && PA != 56)
      $error("priv_reg_gate: PA must be 48, 52 or 56");
  end

  gate_ctl_t   ctl;
  logic        enc_hit_w;
  logic        sel_w;
  verdict_e    verdict_w;
  logic        granted_w;
  logic        refused_w;
  logic        trapped_w;
  logic        wr_commit_w;
  logic [63:0] stored_q;

  assign ctl = '{ns:        ns_state,
                 hyp_trap:  hyp_trap,
                 mon_trap:  mon_trap,
                 fgt_rd:    fgt_rd_trap,
                 fgt_wr:    fgt_wr_trap,
                 fgt_impl:  fgt_impl,
                 mon_fgt_en: mon_fgt_en,
                 has_mon:   has_mon,
                 hyp_en:    hyp_en,
                 undef_opt: mon_undef_opt,
                 undef_prio: mon_undef_prio};

  priv_enc_match u_match (
    .op0 (req_op0),
    .op1 (req_op1),
    .crn (req_crn),
    .crm (req_crm),
    .op2 (req_op2),
    .hit (enc_hit_w)
  );

  priv_access_ladder u_ladder (
    .el       (cur_el),
    .is_write (req_write),
    .ctl      (ctl),
    .verdict  (verdict_w)
  );

  assign sel_w       = req_valid && enc_hit_w;
  assign granted_w   = sel_w && (verdict_w == VERDICT_DONE);
  assign refused_w   = sel_w && (verdict_w == VERDICT_UNDEF);
  assign trapped_w   = sel_w && ((verdict_w == VERDICT_TRAP_HYP) ||
                                 (verdict_w == VERDICT_TRAP_MON));
  assign wr_commit_w = granted_w && req_write;

  priv_region_store #(.PA(PA)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_commit_w),
    .wdata (req_wdata),
    .value (stored_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data     <= '0;
      undef_pulse <= 1'b0;
      trap_pulse  <= 1'b0;
      trap_level  <= 2'd0;
      trap_class  <= 6'd0;
    end else begin
      rd_data     <= (granted_w && !req_write) ? stored_q : 64'd0;
      undef_pulse <= refused_w;
      trap_pulse  <= trapped_w;
      trap_level  <= trapped_w ? ((verdict_w == VERDICT_TRAP_MON) ? 2'd3 : 2'd2) : 2'd0;
      trap_class  <= trapped_w ? TRAP_EC : 6'd0;
    end
  end

endmodule

// File: rtl/priv_reg_gate_chk.sv
module priv_reg_gate_chk #(
  parameter int PA = 52
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [1:0]  cur_el,
  input logic        ns_state,
  input logic        hit,
  input logic        granted,
  input logic [63:0] stored_q,
  input logic [63:0] rd_data,
  input logic        undef_pulse,
  input logic        trap_pulse,
  input logic [1:0]  trap_level,
  input logic [5:0]  trap_class
);
  localparam logic [63:0] LEGAL = ((64'd1 << PA) - 64'd1) & ~64'hFFFE;

  assert_ignore_other_enc_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> (!undef_pulse && !trap_pulse && rd_data == 64'd0 && $stable(stored_q)));

  assert_level0_undef_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && cur_el == 2'd0) |=> undef_pulse);

  assert_level3_secure_undef_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit && cur_el == 2'd3 && !ns_state) |=> undef_pulse);

  assert_trap_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_pulse |-> (trap_class == 6'h18 && trap_level[1]));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LEGAL) == 64'd0);

  assert_single_outcome_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(undef_pulse && trap_pulse));

  assert_refused_write_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && hit && !granted) |=> $stable(stored_q));

  assert_read_returns_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && granted) |=> (rd_data == $past(stored_q)));
endmodule

bind priv_reg_gate priv_reg_gate_chk #(.PA(PA)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_write   (req_write),
  .cur_el      (cur_el),
  .ns_state    (ns_state),
  .hit         (enc_hit_w),
  .granted     (granted_w),
  .stored_q    (stored_q),
  .rd_data     (rd_data),
  .undef_pulse (undef_pulse),
  .trap_pulse  (trap_pulse),
  .trap_level  (trap_level),
  .trap_class  (trap_class)
);

// File: tb/priv_reg_gate_bench.sv
module priv_reg_gate_bench;
  localparam int BPA = 52;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [1:0]  req_op0 = 2'd3;
  logic [2:0]  req_op1 = 3'd0;
  logic [3:0]  req_crn = 4'd10, req_crm = 4'd4;
  logic [2:0]  req_op2 = 3'd0;
  logic [63:0] req_wdata = '0;
  logic [1:0]  cur_el = 2'd3;
  logic ns_state = 1'b1, hyp_trap = 1'b0, mon_trap = 1'b0, fgt_rd_trap = 1'b0;
  logic fgt_wr_trap = 1'b0, fgt_impl = 1'b0, mon_fgt_en = 1'b0, has_mon = 1'b1;
  logic hyp_en = 1'b0, mon_undef_opt = 1'b0, mon_undef_prio = 1'b0;
  logic [63:0] rd_data;
  logic        undef_pulse, trap_pulse;
  logic [1:0]  trap_level;
  logic [5:0]  trap_class;

  always #5 clk = ~clk;

  priv_reg_gate #(.PA(BPA)) u_priv_reg_gate (.*);

  int compared = 0, mismatched = 0;
  bit done = 1'b0;
  logic [63:0] model_reg = '0;
  localparam logic [63:0] MODEL_MASK = (((64'd1 << BPA) - 64'd1) & ~64'hFFFF) | 64'd1;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected outcome: 0 complete, 1 undefined, 2 trap to level 2, 3 trap to level 3
  function automatic int expect_outcome(input bit wr);
    bit fg;
    int mt;
    mt = mon_undef_opt ? 1 : 3;
    if (cur_el == 2'd0) return 1;
    if (cur_el == 2'd3) return ns_state ? 0 : 1;
    if (cur_el == 2'd2) begin
      if (!has_mon) return 0;
      if (!ns_state) return 1;
      if (mon_trap) return mon_undef_prio ? 1 : mt;
      return 0;
    end
    if (has_mon && mon_trap && mon_undef_prio) return 1;
    if (has_mon && !ns_state) return 1;
    if (hyp_en && hyp_trap) return 2;
    fg = wr ? fgt_wr_trap : fgt_rd_trap;
    if (hyp_en && fgt_impl && fg && (mon_fgt_en || !has_mon)) return 2;
    if (has_mon && mon_trap) return mt;
    return 0;
  endfunction

  task automatic access(input string tag, input bit wr, input logic [63:0] wd, input bit match);
    int oc;
    string t;
    logic [63:0] exp_rd;
    @(negedge clk);
    req_valid = 1'b1;
    req_write = wr;
    req_wdata = wd;
    req_op0 = 2'd3; req_op1 = 3'd0; req_crn = 4'd10; req_crm = 4'd4; req_op2 = 3'd0;
    if (!match) begin
      case ($urandom % 5)
        0: req_op0 = 2'($urandom % 3);
        1: req_op1 = 3'(1 + $urandom % 7);
        2: req_crn = 4'd11;
        3: req_crm = 4'd5;
        default: req_op2 = 3'(1 + $urandom % 7);
      endcase
    end
    oc = match ? expect_outcome(wr) : -1;
    if (tag != "") t = tag;
    else if (!match) t = "R1";
    else case (cur_el)
      2'd0: t = "R2";
      2'd1: t = "R3";
      2'd2: t = "R5";
      default: t = "R6";
    endcase
    exp_rd = (oc == 0 && !wr) ? model_reg : 64'd0;
    @(posedge clk);
    if (oc == 0 && wr) model_reg = wd & MODEL_MASK;
    #1;
    check({t, " undef_pulse"}, 64'(undef_pulse), 64'(oc == 1));
    check({t, " trap_pulse"}, 64'(trap_pulse), 64'(oc >= 2));
    check("R7 trap_level", 64'(trap_level), (oc >= 2) ? 64'(oc) : 64'd0);
    check("R7 trap_class", 64'(trap_class), (oc >= 2) ? 64'h18 : 64'd0);
    check({t, "/R12 rd_data"}, rd_data, exp_rd);
    req_valid = 1'b0;
    @(posedge clk);
    #1;
    check("R11 pulse ends", 64'({undef_pulse, trap_pulse}), 64'd0);
    check("R12 rd_data idle", rd_data, 64'd0);
  endtask

  task automatic ctl_clear;
    ns_state = 1'b1; hyp_trap = 1'b0; mon_trap = 1'b0; fgt_rd_trap = 1'b0;
    fgt_wr_trap = 1'b0; fgt_impl = 1'b0; mon_fgt_en = 1'b0; has_mon = 1'b1;
    hyp_en = 1'b0; mon_undef_opt = 1'b0; mon_undef_prio = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset rd_data", rd_data, 64'd0);
    check("R10 reset pulses", 64'({undef_pulse, trap_pulse}), 64'd0);
    @(negedge clk) rst_n = 1'b1;

    ctl_clear(); cur_el = 2'd3;
    access("R10 read after reset", 1'b0, 64'd0, 1'b1);
    access("R9 write ones", 1'b1, '1, 1'b1);
    access("R9 masked readback", 1'b0, 64'd0, 1'b1);
    access("R8 clear valid", 1'b1, 64'h000A_BCDE_1234_0000, 1'b1);
    access("R8 valid reads 0", 1'b0, 64'd0, 1'b1);
    access("R1 other encoding write", 1'b1, 64'h1, 1'b0);
    access("R1 register unchanged", 1'b0, 64'd0, 1'b1);

    cur_el = 2'd0;
    access("R2 level0 read", 1'b0, 64'd0, 1'b1);

    cur_el = 2'd1; hyp_en = 1'b1; hyp_trap = 1'b1; mon_trap = 1'b1; mon_undef_prio = 1'b1;
    access("R3 undef priority over hyp trap", 1'b0, 64'd0, 1'b1);
    ctl_clear(); cur_el = 2'd1; hyp_en = 1'b1; fgt_impl = 1'b1; mon_fgt_en = 1'b1;
    fgt_rd_trap = 1'b1;
    access("R4 read bit, write completes", 1'b1, 64'h0000_0012_3456_0001, 1'b1);
    access("R4 read bit traps read", 1'b0, 64'd0, 1'b1);
    fgt_rd_trap = 1'b0; fgt_wr_trap = 1'b1;
    access("R4 write bit traps write", 1'b1, 64'hFFFF, 1'b1);
    mon_fgt_en = 1'b0;
    access("R4 monitor blocks fine-grained", 1'b1, 64'h0000_0077_0000_0001, 1'b1);
    has_mon = 1'b0;
    access("R4 no monitor allows fine-grained", 1'b1, 64'h0, 1'b1);
    ctl_clear(); cur_el = 2'd1; mon_trap = 1'b1;
    access("R3 trap to level 3", 1'b1, 64'h0, 1'b1);
    access("R11 refused write kept", 1'b0, 64'd0, 1'b1);
    cur_el = 2'd2; mon_undef_opt = 1'b1;
    access("R5 monitor trap undefined", 1'b0, 64'd0, 1'b1);
    ctl_clear(); cur_el = 2'd2; ns_state = 1'b0;
    access("R5 secure undefined", 1'b0, 64'd0, 1'b1);
    cur_el = 2'd3;
    access("R6 level3 secure", 1'b0, 64'd0, 1'b1);

    for (int i = 0; i < 3000; i++) begin
      cur_el        = 2'($urandom % 4);
      ns_state      = ($urandom % 4) != 0;
      hyp_trap      = ($urandom % 4) == 0;
      mon_trap      = ($urandom % 4) == 0;
      fgt_rd_trap   = ($urandom % 3) == 0;
      fgt_wr_trap   = ($urandom % 3) == 0;
      fgt_impl      = $urandom % 2;
      mon_fgt_en    = $urandom % 2;
      has_mon       = ($urandom % 4) != 0;
      hyp_en        = $urandom % 2;
      mon_undef_opt = $urandom % 2;
      mon_undef_prio = $urandom % 2;
      access("", 1'($urandom % 2), {$urandom, $urandom}, ($urandom % 8) != 0);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule